// File: doc/BRIEF.md
# Erased Sector Zero-Bit Detector

A freshly erased flash sector reads back as all ones in both its data and its stored check bytes. A BCH decoder sees such a sector as hopelessly corrupt, because the check bytes of an all-ones sector do not match its data. This block sits next to the decoder on the read path. It watches the bytes of one sector go by, counts the bits that read as zero, and decides whether an uncorrectable sector is really an erased one with a handful of flipped bits.

Bytes arrive one per beat on a valid/ready stream: the data bytes first, then the stored check bytes, with a last flag on the final byte. On that final beat the block also samples the decoder's error count. One cycle later it issues a one-cycle verdict. The verdict classes are clean, corrected, erased and failed. When the verdict is erased, a fill command tells the data path to overwrite the sector's data bytes with 0xFF and to report the sector as good. The zero count saturates just above the correction limit and stops growing once the limit is passed, so the counters stay a few bits wide.

Top module: `erased_sector_detect`

## Requirements
- R1: Each accepted byte contributes the number of its bits that are 0. Contributions from data bytes and from stored check bytes add into one total for the sector.
- R2: A sector whose last flag arrives on any beat other than beat DATA_BYTES+ECC_BYTES gets res_len_err_o=1 and verdict 3 (failed), with res_fill_o=0, whatever its contents.
- R3: A full-length sector whose sampled decoder count is 0 gets verdict 0 (clean) and no fill.
- R4: A full-length sector whose decoder count is from 1 to LIMIT gets verdict 1 (corrected) and no fill, regardless of its zero count.
- R5: A full-length sector whose decoder count exceeds LIMIT and whose zero total is LIMIT or less gets verdict 2 (erased) with res_fill_o=1.
- R6: A full-length sector whose decoder count exceeds LIMIT and whose zero total exceeds LIMIT gets verdict 3 (failed) and no fill. Counting saturates, so any total above LIMIT gives the same result.
- R7: res_valid_o is high for exactly the one cycle after the last byte is accepted. Beats with s_valid_i low add nothing. Outside a verdict cycle, res_fill_o and res_len_err_o are 0.
- R8: The zero total and the byte position restart on the first beat after a last flag, so back-to-back sectors are judged independently.
- R9: While rst_ni is low, s_ready_o and res_valid_o are 0. From the first clock edge after reset is released, s_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_valid_i | input | 1 | Byte beat valid |
| s_ready_o | output | 1 | Block accepts beats |
| s_data_i | input | 8 | Sector byte (data, then check bytes) |
| s_last_i | input | 1 | Final byte of the sector |
| dec_err_cnt_i | input | ERR_W | Decoder error count, sampled with the last beat |
| res_valid_o | output | 1 | Verdict strobe |
| res_verdict_o | output | 2 | 0 clean, 1 corrected, 2 erased, 3 failed |
| res_fill_o | output | 1 | Overwrite data bytes with 0xFF |
| res_len_err_o | output | 1 | Sector length mismatch |

## Verification
The hardest case to reach from the ports is a zero total that passes the limit while the block is still in the check-byte region, or that straddles the data and check regions. In that case the early stop and the saturation both act before the last beat. The bench builds sectors with a reduced data length. It places a chosen number of zero bits only in the data bytes, only in the check bytes, or alternating between the two, and sweeps the count across the limit. It also sends back-to-back sectors in which a saturated failing sector is followed at once by an erased one.

// File: rtl/esd_pkg.sv
package esd_pkg;
  localparam int BYTE_W = 8;
  localparam int PC_W   = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    VC_CLEAN  = 2'd0,
    VC_CORR   = 2'd1,
    VC_ERASED = 2'd2,
    VC_FAIL   = 2'd3
  } verdict_e;
endpackage

// File: rtl/esd_zero_count.sv
module esd_zero_count
  import esd_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output logic [PC_W-1:0]   zeros_o
);
  logic [BYTE_W-1:0] inv;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_inv
    assign inv[b] = ~byte_i[b];
  end

  always_comb begin
    zeros_o = '0;
    for (int b = 0; b < BYTE_W; b++) zeros_o = zeros_o + PC_W'(inv[b]);
  end
endmodule

// File: rtl/esd_accum.sv
module esd_accum
  import esd_pkg::*;
#(
  parameter int DATA_BYTES = 512,
  parameter int ECC_BYTES  = 13,
  parameter int LIMIT      = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            beat_i,
  input  logic            last_i,
  input  logic [PC_W-1:0] zeros_i,
  output logic            len_ok_o,
  output logic            zero_ok_o
);
  localparam int TOTAL = DATA_BYTES + ECC_BYTES;
  localparam int CNT_W = $clog2(TOTAL + 2);
  localparam int ZW    = $clog2(LIMIT + 2);
  localparam int SW    = ZW + PC_W + 1;
  localparam logic [CNT_W-1:0] TOTAL_C = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(TOTAL + 1);
  localparam logic [CNT_W-1:0] DATA_C  = CNT_W'(DATA_BYTES);
  localparam logic [SW-1:0]    SAT_C   = SW'(LIMIT + 1);
  localparam logic [SW-1:0]    LIM_C   = SW'(LIMIT);

  logic             sop_q, over_q;
  logic [CNT_W-1:0] byte_q;
  logic [ZW-1:0]    dz_q, ez_q;

  logic             over_base, over_nxt, in_ecc;
  logic [CNT_W-1:0] byte_base, byte_nxt;
  logic [ZW-1:0]    dz_base, ez_base, dz_nxt, ez_nxt;
  logic [SW-1:0]    sum_nxt;

  function automatic logic [ZW-1:0] sat_add(logic [ZW-1:0] a, logic [PC_W-1:0] b);
    logic [SW-1:0] t;
    t = SW'(a) + SW'(b);
    return (t > SAT_C) ? SAT_C[ZW-1:0] : t[ZW-1:0];
  endfunction

  always_comb begin
    byte_base = sop_q ? '0   : byte_q;
    dz_base   = sop_q ? '0   : dz_q;
    ez_base   = sop_q ? '0   : ez_q;
    over_base = sop_q ? 1'b0 : over_q;
    in_ecc    = byte_base >= DATA_C;
    dz_nxt    = dz_base;
    ez_nxt    = ez_base;
    // early exit: freeze both counters once the limit is passed
    if (!over_base) begin
      if (in_ecc) ez_nxt = sat_add(ez_base, zeros_i);
      else        dz_nxt = sat_add(dz_base, zeros_i);
    end
    sum_nxt  = SW'(dz_nxt) + SW'(ez_nxt);
    over_nxt = over_base | (sum_nxt > LIM_C);
    byte_nxt = (byte_base == MAX_C) ? byte_base : byte_base + 1'b1;
  end

  assign len_ok_o  = byte_nxt == TOTAL_C;
  assign zero_ok_o = !over_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sop_q  <= 1'b1;
      over_q <= 1'b0;
      byte_q <= '0;
      dz_q   <= '0;
      ez_q   <= '0;
    end else if (beat_i) begin
      sop_q  <= last_i;
      over_q <= over_nxt;
      byte_q <= byte_nxt;
      dz_q   <= dz_nxt;
      ez_q   <= ez_nxt;
    end
  end
endmodule

// File: rtl/esd_decide.sv
module esd_decide
  import esd_pkg::*;
#(
  parameter int LIMIT = 8,
  parameter int ERR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             len_ok_i,
  input  logic             zero_ok_i,
  input  logic [ERR_W-1:0] err_cnt_i,
  output logic             valid_o,
  output verdict_e         verdict_o,
  output logic             fill_o,
  output logic             len_err_o
);
  localparam logic [ERR_W-1:0] LIM_C = ERR_W'(LIMIT);

  verdict_e v_d;

  always_comb begin
    if (!len_ok_i)               v_d = VC_FAIL;
    else if (err_cnt_i == '0)    v_d = VC_CLEAN;
    else if (err_cnt_i <= LIM_C) v_d = VC_CORR;
    else if (zero_ok_i)          v_d = VC_ERASED;
    else                         v_d = VC_FAIL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      verdict_o <= VC_CLEAN;
      fill_o    <= 1'b0;
      len_err_o <= 1'b0;
    end else begin
      valid_o   <= fire_i;
      verdict_o <= fire_i ? v_d : VC_CLEAN;
      fill_o    <= fire_i && len_ok_i && (err_cnt_i > LIM_C) && zero_ok_i;
      len_err_o <= fire_i && !len_ok_i;
    end
  end
endmodule

// File: rtl/erased_sector_detect.sv
module erased_sector_detect
  import esd_pkg::*;
#(
  parameter int DATA_BYTES = 512,
  parameter int ECC_BYTES  = 13,
  parameter int LIMIT      = 8,
  parameter int ERR_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic [7:0]       s_data_i,
  input  logic             s_last_i,
  input  logic [ERR_W-1:0] dec_err_cnt_i,
  output logic             res_valid_o,
  output logic [1:0]       res_verdict_o,
  output logic             res_fill_o,
  output logic             res_len_err_o
);
  logic            ready_q, beat, len_ok, zero_ok;
  logic [PC_W-1:0] zeros;
  verdict_e        verdict;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  assign s_ready_o = ready_q;
  assign beat      = s_valid_i & ready_q;

  esd_zero_count u_zc (
    .byte_i  (s_data_i),
    .zeros_o (zeros)
  );

  esd_accum #(
    .DATA_BYTES (DATA_BYTES),
    .ECC_BYTES  (ECC_BYTES),
    .LIMIT      (LIMIT)
  ) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_i    (beat),
    .last_i    (s_last_i),
    .zeros_i   (zeros),
    .len_ok_o  (len_ok),
    .zero_ok_o (zero_ok)
  );

  esd_decide #(
    .LIMIT (LIMIT),
    .ERR_W (ERR_W)
  ) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (beat & s_last_i),
    .len_ok_i  (len_ok),
    .zero_ok_i (zero_ok),
    .err_cnt_i (dec_err_cnt_i),
    .valid_o   (res_valid_o),
    .verdict_o (verdict),
    .fill_o    (res_fill_o),
    .len_err_o (res_len_err_o)
  );

  assign res_verdict_o = verdict;
endmodule

// File: rtl/erased_sector_detect_chk.sv
module erased_sector_detect_chk #(
  parameter int LIMIT = 8,
  parameter int ERR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             s_valid_i,
  input logic             s_ready_o,
  input logic             s_last_i,
  input logic [ERR_W-1:0] dec_err_cnt_i,
  input logic             res_valid_o,
  input logic [1:0]       res_verdict_o,
  input logic             res_fill_o,
  input logic             res_len_err_o
);
  AST_VALID_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o && s_last_i) |=> res_valid_o); // R7
  AST_NO_STRAY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_valid_i && s_ready_o && s_last_i) |=> !res_valid_o); // R7
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!res_fill_o && !res_len_err_o)); // R7
  AST_FILL_NEEDS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_fill_o |-> (int'($past(dec_err_cnt_i)) > LIMIT)); // R5
  AST_CLEAN_ZERO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_verdict_o == 2'd0) |-> ($past(dec_err_cnt_i) == '0)); // R3
  AST_LEN_NO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_len_err_o |-> (res_verdict_o == 2'd3 && !res_fill_o)); // R2
  AST_FILL_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_fill_o == (res_verdict_o == 2'd2))); // R5
endmodule

bind erased_sector_detect erased_sector_detect_chk #(
  .LIMIT (LIMIT),
  .ERR_W (ERR_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .s_valid_i     (s_valid_i),
  .s_ready_o     (s_ready_o),
  .s_last_i      (s_last_i),
  .dec_err_cnt_i (dec_err_cnt_i),
  .res_valid_o   (res_valid_o),
  .res_verdict_o (res_verdict_o),
  .res_fill_o    (res_fill_o),
  .res_len_err_o (res_len_err_o)
);

// File: tb/tb_erased_sector_detect.sv
`timescale 1ns/1ps
module tb_erased_sector_detect;
  localparam int DB  = 16;
  localparam int EB  = 3;
  localparam int LIM = 8;
  localparam int EW  = 4;
  localparam int TOT = DB + EB;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          s_valid_i = 1'b0;
  logic          s_ready_o;
  logic [7:0]    s_data_i = '0;
  logic          s_last_i = 1'b0;
  logic [EW-1:0] dec_err_cnt_i = '0;
  logic          res_valid_o;
  logic [1:0]    res_verdict_o;
  logic          res_fill_o;
  logic          res_len_err_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] sbuf [0:31];
  bit    pend = 1'b0;
  int    exp_v, exp_f, exp_l;
  string exp_tag;
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk_i = ~clk_i;

  erased_sector_detect #(
    .DATA_BYTES (DB),
    .ECC_BYTES  (EB),
    .LIMIT      (LIM),
    .ERR_W      (EW)
  ) dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .s_valid_i     (s_valid_i),
    .s_ready_o     (s_ready_o),
    .s_data_i      (s_data_i),
    .s_last_i      (s_last_i),
    .dec_err_cnt_i (dec_err_cnt_i),
    .res_valid_o   (res_valid_o),
    .res_verdict_o (res_verdict_o),
    .res_fill_o    (res_fill_o),
    .res_len_err_o (res_len_err_o)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // called at a negedge before driving inputs
  task automatic service();
    checks++;
    if (pend) begin
      if (res_valid_o !== 1'b1 || int'(res_verdict_o) != exp_v ||
          int'(res_fill_o) != exp_f || int'(res_len_err_o) != exp_l) begin
        errors++;
        $display("FAIL %s: valid=%0d verdict=%0d fill=%0d lenerr=%0d expected valid=1 verdict=%0d fill=%0d lenerr=%0d",
                 exp_tag, res_valid_o, res_verdict_o, res_fill_o, res_len_err_o, exp_v, exp_f, exp_l);
      end
      pend = 1'b0;
    end else if (res_valid_o !== 1'b0 || res_fill_o !== 1'b0 || res_len_err_o !== 1'b0) begin
      errors++;
      $display("FAIL R7 idle: valid=%0d fill=%0d lenerr=%0d expected 0 0 0",
               res_valid_o, res_fill_o, res_len_err_o);
    end
  endtask

  task automatic set_ff();
    for (int i = 0; i < 32; i++) sbuf[i] = 8'hFF;
  endtask

  // mode 0: data only, 1: check bytes only, 2: alternating
  task automatic set_zeros(input int z, input int mode);
    set_ff();
    for (int k = 0; k < z; k++) begin
      int idx, bitp;
      case (mode)
        0: begin idx = k / 8; bitp = k % 8; end
        1: begin idx = DB + k / 8; bitp = k % 8; end
        default: begin
          idx  = (k % 2 == 0) ? (k / 16) : (DB + k / 16);
          bitp = (k / 2) % 8;
        end
      endcase
      sbuf[idx][bitp] = 1'b0;
    end
  endtask

  task automatic send(input int len, input int err, input bit gaps, input string tag);
    int zc = 0;
    for (int i = 0; i < len; i++) zc += $countones(~sbuf[i]);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 4 == 2)) begin
        @(negedge clk_i); service();
        s_valid_i = 1'b0; s_last_i = 1'b0; s_data_i = 8'h00;
        dec_err_cnt_i = EW'(15 - err);
      end
      @(negedge clk_i); service();
      s_valid_i = 1'b1;
      s_data_i = sbuf[i];
      s_last_i = (i == len - 1);
      dec_err_cnt_i = EW'(err);
    end
    if (len != TOT)     begin exp_v = 3; exp_l = 1; end
    else begin
      exp_l = 0;
      if (err == 0)        exp_v = 0;
      else if (err <= LIM) exp_v = 1;
      else if (zc <= LIM)  exp_v = 2;
      else                 exp_v = 3;
    end
    exp_f = (exp_v == 2) ? 1 : 0;
    exp_tag = $sformatf("%s len=%0d err=%0d zeros=%0d", tag, len, err, zc);
    pend = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); service();
      s_valid_i = 1'b0; s_last_i = 1'b0; s_data_i = 8'h00;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk_i);
    checks++;
    if (s_ready_o !== 1'b0 || res_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 in reset: ready=%0d valid=%0d expected 0 0", s_ready_o, res_valid_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (s_ready_o !== 1'b1) begin
      errors++;
      $display("FAIL R9 after reset: ready=%0d expected 1", s_ready_o);
    end

    // R1 R5 R6: zero count sweep across the limit, three placements
    for (int mode = 0; mode < 3; mode++)
      for (int z = 0; z <= 16; z++) begin
        set_zeros(z, mode);
        send(TOT, 12, 1'b0, (z <= LIM) ? "R5 R1" : "R6 R1");
        idle(1);
      end

    // R3 R4 R5 R6: decoder count sweep
    for (int z = 0; z < 3; z++)
      for (int e = 0; e < 16; e++) begin
        set_zeros(z * 6, 2);
        send(TOT, e, 1'b0, (e == 0) ? "R3" : (e <= LIM) ? "R4" : "R5 R6");
        idle(1);
      end

    // R2: wrong lengths
    set_ff();
    send(TOT - 1, 12, 1'b0, "R2 short"); idle(1);
    send(TOT + 1, 12, 1'b0, "R2 long");  idle(1);
    send(1, 0, 1'b0, "R2 single");       idle(1);
    send(TOT + 5, 3, 1'b0, "R2 long");   idle(1);

    // R7: stalls inside a sector
    set_zeros(8, 2);  send(TOT, 10, 1'b1, "R7 gaps");
    idle(2);
    set_zeros(9, 1);  send(TOT, 10, 1'b1, "R7 gaps");
    idle(1);

    // R8: back-to-back sectors without idle
    set_zeros(16, 1); send(TOT, 12, 1'b0, "R8 first");
    set_zeros(0, 0);  send(TOT, 12, 1'b0, "R8 second");
    set_ff();         send(TOT - 2, 12, 1'b0, "R8 short first");
    set_zeros(3, 0);  send(TOT, 13, 1'b0, "R8 after short");
    set_zeros(8, 1);  send(TOT, 9, 1'b0, "R8 chain");
    idle(1);

    // R1: pseudo-random byte contents
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < TOT; i++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        sbuf[i] = lcg[7:0] | lcg[15:8] | lcg[23:16] | lcg[31:24] | ((n % 3 == 0) ? 8'hF7 : 8'h00);
      end
      send(TOT, 9 + (n % 7), n[0], "R1 random");
      idle(n % 2);
    end
    idle(2);

    summary();
    $finish;
  end
endmodule